// File: doc/BRIEF.md
# Two-Rail Generalized-Product Chain

This block evaluates a configurable product term over an N-bit input word. A token enters a chain of cells on the main rail. Each cell has a 2x2 steering element and a 1x1 gate. The steering element either keeps the token on its current rail ("bar") or swaps it to the other rail ("cross"). Which of the two it does depends on the cell's input bit and the cell's 2-bit mode. The gate sits on the auxiliary rail and is set only by configuration. When the gate blocks and the token arrives on the auxiliary rail, the token is lost. The result is 1 only when the token leaves the last cell alive and on the main rail.

Plain AND cells, inverted-input AND cells and ignored inputs each come from one cell. An exclusive-OR or exclusive-NOR of two neighbouring inputs comes from a pair of cells. In such a pair, the first cell's gate passes, so the token can ride the auxiliary rail for one cell and then be steered back. A single chain can therefore compute terms such as (a XOR b) AND (c XNOR d) AND e AND NOT f.

The per-cell configuration is held in registers and written in one cycle through a write strobe. Input words arrive over a valid/ready stream. Each result leaves through a one-entry registered output stream, one cycle after it is accepted. An input is accepted on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high when the output stage is empty or is being drained in the same cycle. A result that is presented while `out_ready` is low stays unchanged until it is taken.

Top module: `gp_chain`

## Requirements
- R1: After reset the output stream is empty (`out_valid`=0), `in_ready`=1 and `cfg_err`=0. Every cell is configured bar/bar with its gate blocking, so the first word accepted after reset yields 1 whatever its bits.
- R2: Cell i takes its mode from `cfg_mode_in[2i+1:2i]` and its gate from `cfg_aux_in[i]` (1 = pass). The mode codes are:
  - 00: bar/bar.
  - 01: bar/cross, which is bar when the bit is 1 and cross when it is 0.
  - 10: cross/bar, which is cross when the bit is 1 and bar when it is 0.
  - 11: behaves as bar/bar.
- R3: A cell in mode 01 with its gate blocking passes the token only when its bit is 1. A chain of such cells yields the AND of its bits.
- R4: A cell in mode 10 with its gate blocking passes the token only when its bit is 0.
- R5: A pair of cells forms an XOR of their bits. The pair is cell i in mode 10 with its gate passing, followed by cell i+1 in mode 01 with its gate blocking. The token leaves the pair on the main rail exactly when bit i differs from bit i+1.
- R6: A pair of cells forms an XNOR of their bits. The pair is cell i in mode 10 with its gate passing, followed by cell i+1 in mode 10 with its gate blocking. The token leaves the pair on the main rail exactly when bit i equals bit i+1.
- R7: A token that leaves the last cell on the auxiliary rail gives a result of 0, even when the last cell's gate passes.
- R8: A cell in mode 00 or 11 never moves the token, so its input bit has no effect on the result.
- R9: An exclusive cell is one whose gate passes and whose mode is 01 or 10. When the number of exclusive cells exceeds MAX_XCELLS, `cfg_err` is 1 and every result is 0. A count equal to MAX_XCELLS is allowed.
- R10: `in_ready` = !`out_valid` || `out_ready`. While `out_valid`=1 and `out_ready`=0, `out_valid` and `out_bit` hold. An accepted word shows its result in the next cycle.
- R11: A configuration write takes effect for words accepted in later cycles. A word accepted in the same cycle as the write is evaluated with the old configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode_in | input | 2*N_CELLS | Steering mode per cell, 2 bits each |
| cfg_aux_in | input | N_CELLS | Auxiliary-gate pass enable per cell |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Input word can be accepted |
| in_bits | input | N_CELLS | Logic input word, bit i steers cell i |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Downstream takes the result |
| out_bit | output | 1 | Product result |
| cfg_err | output | 1 | Too many exclusive cells configured |

## Verification
The bench builds the chain with N_CELLS=8 and MAX_XCELLS=3. Eight cells hold three XOR pairs exactly at the cap, and a fourth pair pushes the count over it, so both sides of the R9 limit can be reached. The same width leaves room for one configuration that mixes XOR, XNOR, plain and inverted cells. It also allows a dangling cross at the last cell. Back-pressure and a configuration write that lands in the same cycle as an input are tested by directed sequences.

// File: rtl/gp_pkg.sv
package gp_pkg;

  localparam logic [1:0] MODE_BAR_BAR   = 2'b00;
  localparam logic [1:0] MODE_BAR_CROSS = 2'b01; // bar at 1, cross at 0
  localparam logic [1:0] MODE_CROSS_BAR = 2'b10; // cross at 1, bar at 0
  localparam logic [1:0] MODE_SPARE     = 2'b11; // treated as bar/bar

  typedef struct packed {
    logic alive;
    logic on_aux;
  } token_t;

  function automatic logic swaps(input logic [1:0] mode, input logic b);
    case (mode)
      MODE_BAR_CROSS: swaps = ~b;
      MODE_CROSS_BAR: swaps = b;
      default:        swaps = 1'b0;
    endcase
  endfunction

  function automatic logic is_steering(input logic [1:0] mode);
    is_steering = (mode == MODE_BAR_CROSS) || (mode == MODE_CROSS_BAR);
  endfunction

endpackage

// File: rtl/gp_cell.sv
module gp_cell
  import gp_pkg::*;
(
  input  token_t     tok_in,
  input  logic       in_bit,
  input  logic [1:0] mode,
  input  logic       aux_pass,
  output token_t     tok_out
);
  logic rail_after;

  always_comb begin
    rail_after     = tok_in.on_aux ^ swaps(mode, in_bit);
    tok_out.on_aux = rail_after;
    tok_out.alive  = tok_in.alive && !(rail_after && !aux_pass);
  end
endmodule

// File: rtl/gp_xcount.sv
module gp_xcount
  import gp_pkg::*;
#(
  parameter int N_CELLS    = 8,
  parameter int MAX_XCELLS = 4
) (
  input  logic [2*N_CELLS-1:0] modes,
  input  logic [N_CELLS-1:0]   aux_pass,
  output logic                 over_cap
);
  localparam int CW = $clog2(N_CELLS + 1) + 1;

  logic [CW-1:0] tally;

  always_comb begin
    tally = '0;
    for (int i = 0; i < N_CELLS; i++) begin
      tally = tally + CW'(aux_pass[i] && is_steering(modes[2*i +: 2]));
    end
    over_cap = (32'(tally) > MAX_XCELLS);
  end
endmodule

// File: rtl/gp_out_stage.sv
module gp_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic take,
  input  logic res_in,
  input  logic out_ready,
  output logic out_valid,
  output logic out_bit,
  output logic in_ready
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_bit   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_bit   <= res_in;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign in_ready = !out_valid || out_ready;
endmodule

// File: rtl/gp_chain.sv
module gp_chain
  import gp_pkg::*;
#(
  parameter int N_CELLS    = 8,
  parameter int MAX_XCELLS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_we,
  input  logic [2*N_CELLS-1:0] cfg_mode_in,
  input  logic [N_CELLS-1:0]   cfg_aux_in,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [N_CELLS-1:0]   in_bits,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic                 out_bit,
  output logic                 cfg_err
);
  localparam int MW = 2 * N_CELLS;

  logic [MW-1:0]      mode_q;
  logic [N_CELLS-1:0] aux_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      aux_q  <= '0;
    end else if (cfg_we) begin
      mode_q <= cfg_mode_in;
      aux_q  <= cfg_aux_in;
    end
  end

  token_t tok [N_CELLS+1];
  assign tok[0] = '{alive: 1'b1, on_aux: 1'b0};

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    gp_cell u_cell (
      .tok_in   (tok[g]),
      .in_bit   (in_bits[g]),
      .mode     (mode_q[2*g +: 2]),
      .aux_pass (aux_q[g]),
      .tok_out  (tok[g+1])
    );
  end

  gp_xcount #(
    .N_CELLS    (N_CELLS),
    .MAX_XCELLS (MAX_XCELLS)
  ) u_xcount (
    .modes    (mode_q),
    .aux_pass (aux_q),
    .over_cap (cfg_err)
  );

  logic result;
  assign result = tok[N_CELLS].alive && !tok[N_CELLS].on_aux && !cfg_err;

  gp_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (in_valid && in_ready),
    .res_in    (result),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_bit   (out_bit),
    .in_ready  (in_ready)
  );
endmodule

// File: rtl/gp_chain_chk.sv
module gp_chain_chk (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic out_bit,
  input logic cfg_err
);
  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bit)));

  // R10
  ready_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R10
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R9
  err_forces_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg_err) |=> (out_valid && !out_bit));
endmodule

bind gp_chain gp_chain_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_bit   (out_bit),
  .cfg_err   (cfg_err)
);

// File: tb/gp_chain_test.sv
module gp_chain_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int MX = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [2*N-1:0] cfg_mode_in = '0;
  logic [N-1:0] cfg_aux_in = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [N-1:0] in_bits = '0;
  logic out_valid;
  logic out_ready = 1'b1;
  logic out_bit;
  logic cfg_err;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_chain #(.N_CELLS(N), .MAX_XCELLS(MX)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode_in(cfg_mode_in),
    .cfg_aux_in(cfg_aux_in), .in_valid(in_valid), .in_ready(in_ready),
    .in_bits(in_bits), .out_valid(out_valid), .out_ready(out_ready),
    .out_bit(out_bit), .cfg_err(cfg_err)
  );

  // {req[3:0], mode[15:0], aux[7:0], bits[7:0], exp_out, exp_err}
  localparam int NV = 22;
  localparam logic [37:0] VEC [NV] = '{
    {4'd3,  16'h5555, 8'h00, 8'hFF, 1'b1, 1'b0}, // R3 all bits 1
    {4'd3,  16'h5555, 8'h00, 8'hFE, 1'b0, 1'b0}, // R3 first bit 0
    {4'd3,  16'h5555, 8'h00, 8'h7F, 1'b0, 1'b0}, // R3 last bit 0
    {4'd4,  16'hAAAA, 8'h00, 8'h00, 1'b1, 1'b0}, // R4 inverted, all 0
    {4'd4,  16'hAAAA, 8'h00, 8'h10, 1'b0, 1'b0}, // R4 one bit 1
    {4'd8,  16'h0000, 8'h00, 8'hA5, 1'b1, 1'b0}, // R8 bar/bar ignores
    {4'd5,  16'h0006, 8'h01, 8'h01, 1'b1, 1'b0}, // R5 1,0
    {4'd5,  16'h0006, 8'h01, 8'h02, 1'b1, 1'b0}, // R5 0,1
    {4'd5,  16'h0006, 8'h01, 8'h03, 1'b0, 1'b0}, // R5 1,1
    {4'd5,  16'h0006, 8'h01, 8'hF0, 1'b0, 1'b0}, // R5 0,0
    {4'd6,  16'h00A0, 8'h04, 8'h0C, 1'b1, 1'b0}, // R6 1,1
    {4'd6,  16'h00A0, 8'h04, 8'h04, 1'b0, 1'b0}, // R6 1,0
    {4'd6,  16'h00A0, 8'h04, 8'h00, 1'b1, 1'b0}, // R6 0,0
    {4'd6,  16'h00A0, 8'h04, 8'h08, 1'b0, 1'b0}, // R6 0,1
    {4'd6,  16'h09A6, 8'h05, 8'h1D, 1'b1, 1'b0}, // R6 mixed term true
    {4'd6,  16'h09A6, 8'h05, 8'h3D, 1'b0, 1'b0}, // R6 mixed term, inverted bit 1
    {4'd7,  16'h8000, 8'h80, 8'h80, 1'b0, 1'b0}, // R7 ends on aux rail
    {4'd7,  16'h8000, 8'h80, 8'h00, 1'b1, 1'b0}, // R7 stays main
    {4'd9,  16'h0666, 8'h15, 8'h15, 1'b1, 1'b0}, // R9 count equals cap
    {4'd9,  16'h6666, 8'h55, 8'h55, 1'b0, 1'b1}, // R9 count over cap
    {4'd2,  16'hFFFF, 8'h00, 8'h3C, 1'b1, 1'b0}, // R2 code 11 is bar/bar
    {4'd2,  16'hFFFF, 8'hFF, 8'h3C, 1'b1, 1'b0}  // R2 code 11, gates pass
  };

  task automatic check(input string tag, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2*N-1:0] m, input logic [N-1:0] a);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode_in = m; cfg_aux_in = a;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // drives one word; returns at the negedge after acceptance
  task automatic send(input logic [N-1:0] b);
    @(negedge clk);
    in_valid = 1'b1; in_bits = b;
    @(posedge clk);
    while (!in_ready) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 out_valid", out_valid, 1'b0);
    check("R1 in_ready", in_ready, 1'b1);
    check("R1 cfg_err", cfg_err, 1'b0);
    send(8'h5A);
    check("R1 first result", out_bit, 1'b1);
    check("R10 result next cycle", out_valid, 1'b1);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[37:34], i);
      write_cfg(v[33:18], v[17:10]);
      check({tag, " err"}, cfg_err, v[0]);
      send(v[9:2]);
      check(tag, out_bit, v[1]);
    end

    // R10 back-pressure
    write_cfg(16'h5555, 8'h00);
    out_ready = 1'b0;
    send(8'hFF);
    check("R10 held valid", out_valid, 1'b1);
    check("R10 held bit", out_bit, 1'b1);
    in_valid = 1'b1; in_bits = 8'h00;
    repeat (3) begin
      @(negedge clk);
      check("R10 in_ready low", in_ready, 1'b0);
      check("R10 bit stable", out_bit, 1'b1);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 next word valid", out_valid, 1'b1);
    check("R10 next word bit", out_bit, 1'b0);
    @(negedge clk);
    check("R10 drained", out_valid, 1'b0);

    // R11 write and accept in the same cycle
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode_in = 16'hAAAA; cfg_aux_in = 8'h00;
    in_valid = 1'b1; in_bits = 8'hFF;
    @(negedge clk);
    cfg_we = 1'b0; in_valid = 1'b0;
    check("R11 old config used", out_bit, 1'b1);
    send(8'hFF);
    check("R11 new config used", out_bit, 1'b0);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule